// File: doc/BRIEF.md
# Fetch Group Aligner

This block takes one instruction-cache line of eight instruction words and a fetch PC, and hands the decoders a group of up to four consecutive instructions starting at that PC, in program order. Because the line holds twice as many words as the group, a full group of four is available from any start position that leaves at least four words before the end of the line. The group is not limited to line-aligned PCs. A barrel rotator moves the word at the PC into decoder slot 0 and the words after it into slots 1 to 3.

When fewer than four words remain before the end of the line, the group is cut short at the line end. The block reports the sequential PC that follows the delivered words, so a truncated fetch resumes exactly at the next line boundary. The PC counts instruction words, not bytes. Its low three bits select the word within the line.

All outputs are registered. They show the group for the inputs that were present at the previous rising clock edge. Tag lookup, branch prediction and joining two lines are done elsewhere.

Top module: `fetch_group_aligner`

## Requirements
- R1: While `rst_n` is low, and after the first edge following its release, up to the first captured fetch, `slot_valid` is 0, every slot word is 0 and `next_pc` is 0.
- R2: For every valid slot k, the slot word equals line word (offset + k). Here offset is `fetch_pc[2:0]`, and line word j occupies bits [32*j+31 : 32*j] of `line_words`.
- R3: With `line_valid` high and offset 0 to 4, all four slots are valid (`slot_valid` = 4'b1111).
- R4: With `line_valid` high and offset 5 to 7, exactly 8 - offset slots are valid. The valid slots are the low ones and contiguous (3'b111, 2'b11 or 1'b1 in the low bits).
- R5: Every slot whose valid bit is clear carries an all-zero word.
- R6: With `line_valid` high, `next_pc` equals `fetch_pc` plus the number of valid slots, modulo 2^32. A truncated group therefore yields the next multiple of 8.
- R7: With `line_valid` low, `slot_valid` is 0 and `next_pc` equals `fetch_pc` (no advance).
- R8: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Fetch PC in instruction-word units; low 3 bits give the position in the line |
| line_valid | input | 1 | The line on `line_words` holds valid instructions |
| line_words | input | 256 | Eight 32-bit instruction words, word j at bits [32*j+31:32*j] |
| slot_words | output | 128 | Four aligned decoder slots, slot k at bits [32*k+31:32*k] |
| slot_valid | output | 4 | Per-slot valid, bit k for slot k |
| next_pc | output | 32 | Sequential PC after the delivered group |

## Verification
The bench walks every offset of the line, so both sides of the full/truncated boundary between offsets 4 and 5 are covered. A design with an off-by-one there would deliver a word from outside the line, or drop a word it should have delivered. Line words are given unique values, so a rotator that indexes in reverse order or by the wrong amount shows up as a misplaced word in some slot. Cycles with the line invalid check that the PC is held. A design that still advanced the PC there would skip instructions. Truncated groups check that `next_pc` lands on the line boundary, and a PC near the top of the address range checks modulo wrap.

// File: rtl/fga_pkg.sv
package fga_pkg;
    localparam int WORD_W  = 32;
    localparam int GROUP_N = 4;
    localparam int LINE_N  = 8;
    localparam int PC_W    = 32;

    localparam int OFF_W = $clog2(LINE_N);
    localparam int CNT_W = $clog2(GROUP_N + 1);

    typedef logic [WORD_W-1:0] insn_word_t;
    typedef logic [OFF_W-1:0]  line_off_t;
    typedef logic [CNT_W-1:0]  grp_cnt_t;
endpackage

// File: rtl/fga_window.sv
// Decides how many slots of the group are filled and which ones.
module fga_window
    import fga_pkg::*;
(
    input  line_off_t          offset,
    input  logic               line_valid,
    output grp_cnt_t           count,
    output logic [GROUP_N-1:0] mask
);
    localparam int REM_W = OFF_W + 1;

    logic [REM_W-1:0] remain;

    // Words left in the line, counting the one at the offset.
    assign remain = REM_W'(LINE_N) - {1'b0, offset};

    always_comb begin
        if (!line_valid) begin
            count = '0;
        end else if (remain >= REM_W'(GROUP_N)) begin
            count = CNT_W'(GROUP_N);
        end else begin
            count = CNT_W'(remain);
        end
    end

    // Slot k is filled when it lies below the count.
    for (genvar k = 0; k < GROUP_N; k++) begin : g_mask
        assign mask[k] = (CNT_W'(k) < count);
    end
endmodule

// File: rtl/fga_rotator.sv
// Steers line word (offset + k) into slot k; slots left empty get zeros.
module fga_rotator
    import fga_pkg::*;
(
    input  logic [LINE_N*WORD_W-1:0]  line_words,
    input  line_off_t                 offset,
    input  logic [GROUP_N-1:0]        mask,
    output logic [GROUP_N*WORD_W-1:0] slots
);
    localparam int IDX_W = OFF_W + 1;

    for (genvar k = 0; k < GROUP_N; k++) begin : g_slot
        logic [IDX_W-1:0] src;
        insn_word_t       pick;

        assign src = {1'b0, offset} + IDX_W'(k);

        always_comb begin
            pick = '0;
            for (int j = 0; j < LINE_N; j++) begin
                if (src == IDX_W'(j)) begin
                    pick = line_words[j*WORD_W +: WORD_W];
                end
            end
        end

        assign slots[k*WORD_W +: WORD_W] = mask[k] ? pick : '0;
    end
endmodule

// File: rtl/fga_pc_step.sv
// Adds the number of delivered words to the fetch PC.
module fga_pc_step
    import fga_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    input  grp_cnt_t        count,
    output logic [PC_W-1:0] pc_next
);
    assign pc_next = pc + PC_W'(count);
endmodule

// File: rtl/fetch_group_aligner.sv
module fetch_group_aligner
    import fga_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PC_W-1:0]           fetch_pc,
    input  logic                      line_valid,
    input  logic [LINE_N*WORD_W-1:0]  line_words,
    output logic [GROUP_N*WORD_W-1:0] slot_words,
    output logic [GROUP_N-1:0]        slot_valid,
    output logic [PC_W-1:0]           next_pc
);
    line_off_t                 offset;
    grp_cnt_t                  count;
    logic [GROUP_N-1:0]        mask;
    logic [GROUP_N*WORD_W-1:0] slots_d;
    logic [PC_W-1:0]           pc_d;

    assign offset = fetch_pc[OFF_W-1:0];

    fga_window u_window (
        .offset     (offset),
        .line_valid (line_valid),
        .count      (count),
        .mask       (mask)
    );

    fga_rotator u_rotator (
        .line_words (line_words),
        .offset     (offset),
        .mask       (mask),
        .slots      (slots_d)
    );

    fga_pc_step u_pc_step (
        .pc      (fetch_pc),
        .count   (count),
        .pc_next (pc_d)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_words <= '0;
            slot_valid <= '0;
            next_pc    <= '0;
        end else begin
            slot_words <= slots_d;
            slot_valid <= mask;
            next_pc    <= pc_d;
        end
    end

    // Set once a real fetch has been captured; guards $past checks.
    logic primed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (slot_valid == '0 && next_pc == '0));

    p_full_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(line_valid) &&
         $past(fetch_pc[OFF_W-1:0]) <= OFF_W'(LINE_N - GROUP_N))
        |-> (&slot_valid));

    p_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid & (slot_valid + 1'b1)) == '0));

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(line_valid))
        |-> (next_pc == $past(fetch_pc) + PC_W'($countones(slot_valid))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(line_valid))
        |-> (slot_valid == '0 && next_pc == $past(fetch_pc)));
endmodule

// File: tb/fetch_group_aligner_tb.sv
module fetch_group_aligner_tb_top;
    localparam int W  = 32;
    localparam int N  = 4;
    localparam int L  = 8;
    localparam int PW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [PW-1:0]   fetch_pc;
    logic            line_valid;
    logic [L*W-1:0]  line_words;
    logic [N*W-1:0]  slot_words;
    logic [N-1:0]    slot_valid;
    logic [PW-1:0]   next_pc;

    fetch_group_aligner dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .line_valid (line_valid),
        .line_words (line_words),
        .slot_words (slot_words),
        .slot_valid (slot_valid),
        .next_pc    (next_pc)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state.
    logic [N-1:0]  e_valid;
    logic [W-1:0]  e_word [N];
    logic [PW-1:0] e_pc;
    bit            e_lv;
    int            e_off;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model();
        int cnt;
        e_lv  = line_valid;
        e_off = int'(fetch_pc % L);
        if (!line_valid)          cnt = 0;
        else if (L - e_off < N)   cnt = L - e_off;
        else                      cnt = N;
        for (int k = 0; k < N; k++) begin
            e_valid[k] = (k < cnt);
            e_word[k]  = (k < cnt) ? line_words[(e_off + k)*W +: W] : '0;
        end
        e_pc = fetch_pc + PW'(cnt);
    endtask

    task automatic compare();
        string vtag;
        vtag = !e_lv ? "R7" : (e_off <= L - N ? "R3" : "R4");
        check(vtag, "slot_valid", 32'(slot_valid), 32'(e_valid));
        for (int k = 0; k < N; k++) begin
            check(e_valid[k] ? "R2" : "R5", $sformatf("slot%0d", k),
                  slot_words[k*W +: W], e_word[k]);
        end
        check(e_lv ? "R6" : "R7", "next_pc", next_pc, e_pc);
    endtask

    task automatic make_line(int seed);
        for (int j = 0; j < L; j++) begin
            line_words[j*W +: W] = 32'hA000_0000 + 32'(seed * 16 + j);
        end
    endtask

    // Compare previous group, apply new inputs, confirm no change before the edge.
    task automatic step(logic [PW-1:0] pc, logic lv, int seed);
        @(negedge clk);
        compare();
        fetch_pc   = pc;
        line_valid = lv;
        make_line(seed);
        #1;
        check("R8", "slot_valid held", 32'(slot_valid), 32'(e_valid));
        check("R8", "next_pc held", next_pc, e_pc);
        model();
    endtask

    initial begin
        rst_n      = 1'b0;
        fetch_pc   = 32'd5;
        line_valid = 1'b1;
        make_line(1);
        repeat (3) @(negedge clk);
        // R1: reset clears all outputs.
        check("R1", "slot_valid", 32'(slot_valid), 32'd0);
        check("R1", "slot0", slot_words[0 +: W], 32'd0);
        check("R1", "next_pc", next_pc, 32'd0);
        rst_n = 1'b1;
        model();

        for (int o = 0; o < L; o++) step(32'd64 + 32'(o), 1'b1, o + 2);
        for (int o = 0; o < L; o++) step(32'd200 + 32'(o), 1'b0, o + 20);
        step(32'hFFFF_FFFC, 1'b1, 40);
        step(32'hFFFF_FFFF, 1'b1, 41);
        step(32'd13, 1'b1, 42);
        step(32'd13, 1'b0, 43);
        for (int i = 0; i < 200; i++) begin
            step($urandom, 1'($urandom % 4 != 0), 50 + i);
        end
        @(negedge clk);
        compare();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule